// File: doc/BRIEF.md
# Superpage-Aware Fully Associative Translation Cache

This block is a small, fully associative translation cache. Each slot holds one page-table translation together with the address-space identifier it belongs to. A translation may describe a base page or a larger page one or two levels up. When an entry is written, the slot derives two masks from the page level. The offset mask covers the bits that pass straight through from the virtual address. The match mask covers the bits that form the tag. Lookups then need no knowledge of the level.

An insert port writes a new translation in one cycle. The inputs are the identifier, a global flag, the virtual and physical addresses, the raw entry word, the physical location of that word and the level. The lookup port is purely combinational. For an identifier and a virtual address it returns a hit flag, the translated physical address, the raw entry word and the entry's physical location. A page walker and a dirty-bit writeback agent sit outside the block, and the location output exists for that agent.

An invalidate port removes entries in one cycle. The caller may restrict the invalidate by identifier, by address, by both or by neither. Global entries survive any invalidate that names an identifier.

Top module: `vtlb_assoc`

## Requirements
- R1: After reset every slot is empty. Every lookup misses, and lk_paddr, lk_pte and lk_pte_addr read zero.
- R2: An insert at level L uses a page offset width of 12 + 9*min(L,2) bits. The stored tag is the virtual address with those low bits cleared, and the stored physical base also has them cleared. On a hit, lk_paddr equals the base ORed with the lookup address's low offset bits. Level codes 2 and 3 behave the same.
- R3: A valid entry hits when two conditions hold. First, it is global or its identifier equals lk_asid. Second, its tag equals lk_vaddr with the entry's offset bits cleared.
- R4: When several entries hit, the outputs come from the lowest-index hitting slot. On a miss, all three data outputs are zero.
- R5: An invalidate with fl_use_asid=0 and fl_use_addr=0 empties every slot.
- R6: An invalidate with only fl_use_addr=1 empties every slot whose tag equals fl_addr with that slot's offset bits cleared. Global slots are included.
- R7: An invalidate with only fl_use_asid=1 empties every non-global slot whose identifier equals fl_asid. Global slots are kept.
- R8: An invalidate with both enables set empties only non-global slots that match both the identifier and the masked address.
- R9: When fl_valid and ins_valid are high in the same cycle, the invalidate is applied and the insert is discarded.
- R10: An insert goes to the lowest-index empty slot. When no slot is empty, it replaces the slot written longest ago.
- R11: An insert becomes visible to lookups from the cycle after it is accepted. A lookup in the insert cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Write a translation this cycle |
| ins_asid | input | ASID_W | Identifier of the new entry |
| ins_global | input | 1 | New entry matches every identifier |
| ins_vaddr | input | VA_W | Virtual address of the new entry |
| ins_paddr | input | PA_W | Physical address of the new entry |
| ins_pte | input | PTE_W | Raw entry word |
| ins_pte_addr | input | PA_W | Physical location of the entry word |
| ins_level | input | LVL_W | Page level, 0 = base page |
| lk_asid | input | ASID_W | Lookup identifier |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a translation |
| lk_paddr | output | PA_W | Translated physical address |
| lk_pte | output | PTE_W | Entry word of the hit |
| lk_pte_addr | output | PA_W | Entry word location of the hit |
| fl_valid | input | 1 | Invalidate this cycle |
| fl_use_asid | input | 1 | Restrict the invalidate to fl_asid |
| fl_asid | input | ASID_W | Identifier to invalidate |
| fl_use_addr | input | 1 | Restrict the invalidate to fl_addr |
| fl_addr | input | VA_W | Address to invalidate |

## Verification
The bench targets superpage lookups whose offset bits differ from the inserted address. A design that built the masks wrongly would miss these lookups or return a merged physical address. It places overlapping base-page and superpage entries so that two slots hit together. A wrong priority would return the other slot's entry word. It checks global entries under every invalidate kind. A design that protected them from address-only invalidates, or failed to protect them from identifier invalidates, would leave the wrong slots alive. It also checks a colliding insert and invalidate, where a wrong priority would bring in a new entry. Finally, it inserts past capacity so that the eviction order shows at the ports.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

  // Invalidate selection kinds, decoded from the two enables
  typedef enum logic [1:0] {
    FK_ALL  = 2'd0,
    FK_ADDR = 2'd1,
    FK_ASID = 2'd2,
    FK_BOTH = 2'd3
  } fl_kind_e;

  function automatic fl_kind_e fl_classify(input logic use_asid, input logic use_addr);
    case ({use_asid, use_addr})
      2'b00:   return FK_ALL;
      2'b01:   return FK_ADDR;
      2'b10:   return FK_ASID;
      default: return FK_BOTH;
    endcase
  endfunction

  // Offset width for a page level; levels beyond the top one clamp to it
  function automatic int unsigned page_shift(input int unsigned lvl,
                                             input int unsigned levels,
                                             input int unsigned offs_w,
                                             input int unsigned idx_w);
    int unsigned l;
    l = (lvl >= levels) ? (levels - 1) : lvl;
    return offs_w + l * idx_w;
  endfunction

  // Vector with the n lowest bits set
  function automatic logic [63:0] low_ones64(input int unsigned n);
    logic [63:0] m;
    for (int unsigned b = 0; b < 64; b++) m[b] = (b < n);
    return m;
  endfunction

endpackage

// File: rtl/vtlb_slot.sv
module vtlb_slot
  import vtlb_pkg::*;
#(
  parameter int VA_W   = 39,
  parameter int PA_W   = 56,
  parameter int PTE_W  = 64,
  parameter int ASID_W = 9,
  parameter int AGE_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [VA_W-1:0]   wr_vtag,
  input  logic [VA_W-1:0]   wr_omask,
  input  logic [PA_W-1:0]   wr_pbase,
  input  logic [PTE_W-1:0]  wr_pte,
  input  logic [PA_W-1:0]   wr_pte_addr,
  input  logic [AGE_W-1:0]  wr_age,
  input  logic              fl_req,
  input  fl_kind_e          fl_kind,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [VA_W-1:0]   fl_addr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              o_valid,
  output logic [AGE_W-1:0]  o_age,
  output logic              o_hit,
  output logic [PA_W-1:0]   o_pbase,
  output logic [VA_W-1:0]   o_omask,
  output logic [PTE_W-1:0]  o_pte,
  output logic [PA_W-1:0]   o_pte_addr
);

  logic              valid_q;
  logic              glob_q;
  logic [ASID_W-1:0] asid_q;
  logic [VA_W-1:0]   vtag_q;
  logic [VA_W-1:0]   omask_q;
  logic [PA_W-1:0]   pbase_q;
  logic [PTE_W-1:0]  pte_q;
  logic [PA_W-1:0]   pte_addr_q;
  logic [AGE_W-1:0]  age_q;

  // Named events used by the assertions
  logic fl_tag_eq;
  logic fl_asid_eq;
  logic fl_select;
  logic kill;

  assign fl_tag_eq  = (vtag_q == (fl_addr & ~omask_q));
  assign fl_asid_eq = (asid_q == fl_asid) && !glob_q;

  always_comb begin
    unique case (fl_kind)
      FK_ALL:  fl_select = 1'b1;
      FK_ADDR: fl_select = fl_tag_eq;
      FK_ASID: fl_select = fl_asid_eq;
      default: fl_select = fl_asid_eq && fl_tag_eq;
    endcase
  end

  assign kill = fl_req && fl_select;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      glob_q     <= 1'b0;
      asid_q     <= '0;
      vtag_q     <= '0;
      omask_q    <= '0;
      pbase_q    <= '0;
      pte_q      <= '0;
      pte_addr_q <= '0;
      age_q      <= '0;
    end else if (kill) begin
      valid_q    <= 1'b0;
    end else if (wr_en) begin
      valid_q    <= 1'b1;
      glob_q     <= wr_glob;
      asid_q     <= wr_asid;
      vtag_q     <= wr_vtag;
      omask_q    <= wr_omask;
      pbase_q    <= wr_pbase;
      pte_q      <= wr_pte;
      pte_addr_q <= wr_pte_addr;
      age_q      <= wr_age;
    end
  end

  assign o_hit      = valid_q && (glob_q || (asid_q == lk_asid)) &&
                      (vtag_q == (lk_vaddr & ~omask_q));
  assign o_valid    = valid_q;
  assign o_age      = age_q;
  assign o_pbase    = pbase_q;
  assign o_omask    = omask_q;
  assign o_pte      = pte_q;
  assign o_pte_addr = pte_addr_q;

  // R7
  glob_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && (fl_kind == FK_ASID || fl_kind == FK_BOTH) && valid_q && glob_q) |=> valid_q);

  // R6
  addr_flush_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_kind == FK_ADDR && valid_q && (vtag_q == (fl_addr & ~omask_q))) |=> !valid_q);

  // R8
  both_needs_asid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_kind == FK_BOTH && valid_q && (asid_q != fl_asid)) |=> valid_q);

endmodule

// File: rtl/vtlb_victim.sv
module vtlb_victim #(
  parameter int N     = 8,
  parameter int AGE_W = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic [AGE_W-1:0] ages [N],
  output logic [IDX_W-1:0] victim_idx
);

  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;
  logic [AGE_W-1:0] old_age;

  // Lowest-index empty slot: scan downward so the lowest index is written last
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // Oldest slot: a strict compare keeps the lower index on a tie
  always_comb begin
    old_idx = '0;
    old_age = ages[0];
    for (int i = 1; i < N; i++) begin
      if (ages[i] < old_age) begin
        old_age = ages[i];
        old_idx = IDX_W'(i);
      end
    end
  end

  assign victim_idx = any_free ? free_idx : old_idx;

  // R10
  pick_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&valid_vec)) |-> !valid_vec[victim_idx]);

endmodule

// File: rtl/vtlb_hitsel.sv
module vtlb_hitsel #(
  parameter int N     = 8,
  parameter int VA_W  = 39,
  parameter int PA_W  = 56,
  parameter int PTE_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     hit_vec,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [PA_W-1:0]  pbase [N],
  input  logic [VA_W-1:0]  omask [N],
  input  logic [PTE_W-1:0] pte [N],
  input  logic [PA_W-1:0]  pte_addr [N],
  output logic             any_hit,
  output logic [PA_W-1:0]  paddr,
  output logic [PTE_W-1:0] pte_out,
  output logic [PA_W-1:0]  pte_addr_out
);

  logic [N-1:0] grant_oh;

  // Lowest-index grant: each slot is granted only if no lower slot hits
  always_comb begin
    logic lower;
    lower = 1'b0;
    for (int i = 0; i < N; i++) begin
      grant_oh[i] = hit_vec[i] && !lower;
      lower       = lower || hit_vec[i];
    end
  end

  // AND-OR mux of the granted slot; zero when nothing is granted
  always_comb begin
    paddr        = '0;
    pte_out      = '0;
    pte_addr_out = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_oh[i]) begin
        paddr        = paddr | pbase[i] | PA_W'(lk_vaddr & omask[i]);
        pte_out      = pte_out | pte[i];
        pte_addr_out = pte_addr_out | pte_addr[i];
      end
    end
  end

  assign any_hit = |grant_oh;

  // R4
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh) && ((grant_oh & ~hit_vec) == '0));

endmodule

// File: rtl/vtlb_assoc.sv
module vtlb_assoc
  import vtlb_pkg::*;
#(
  parameter int N      = 8,
  parameter int VA_W   = 39,
  parameter int PA_W   = 56,
  parameter int PTE_W  = 64,
  parameter int ASID_W = 9,
  parameter int LEVELS = 3,
  parameter int OFFS_W = 12,
  parameter int IDX_W  = 9,
  parameter int AGE_W  = 32,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ASID_W-1:0] ins_asid,
  input  logic              ins_global,
  input  logic [VA_W-1:0]   ins_vaddr,
  input  logic [PA_W-1:0]   ins_paddr,
  input  logic [PTE_W-1:0]  ins_pte,
  input  logic [PA_W-1:0]   ins_pte_addr,
  input  logic [LVL_W-1:0]  ins_level,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [PTE_W-1:0]  lk_pte,
  output logic [PA_W-1:0]   lk_pte_addr,
  input  logic              fl_valid,
  input  logic              fl_use_asid,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic              fl_use_addr,
  input  logic [VA_W-1:0]   fl_addr
);

  localparam int SLOT_W = (N > 1) ? $clog2(N) : 1;

  // Free-running age source
  logic [AGE_W-1:0] age_ctr;
  always_ff @(posedge clk) begin
    if (!rst_n) age_ctr <= '0;
    else        age_ctr <= age_ctr + 1'b1;
  end

  // Insert-side mask arithmetic
  logic [VA_W-1:0] wr_omask;
  logic [VA_W-1:0] wr_vtag;
  logic [PA_W-1:0] wr_pbase;

  always_comb begin
    int unsigned sh;
    sh       = page_shift(32'(ins_level), LEVELS, OFFS_W, IDX_W);
    wr_omask = VA_W'(low_ones64(sh));
    wr_vtag  = ins_vaddr & ~wr_omask;
    wr_pbase = ins_paddr & ~PA_W'(low_ones64(sh));
  end

  // Named events: invalidate wins over a colliding insert
  fl_kind_e          fl_kind;
  logic              ins_go;
  logic [SLOT_W-1:0] victim_idx;
  logic [N-1:0]      wr_vec;

  assign fl_kind = fl_classify(fl_use_asid, fl_use_addr);
  assign ins_go  = ins_valid && !fl_valid;

  always_comb begin
    wr_vec = '0;
    wr_vec[victim_idx] = ins_go;
  end

  logic [N-1:0]     valid_vec;
  logic [N-1:0]     hit_vec;
  logic [AGE_W-1:0] e_age      [N];
  logic [PA_W-1:0]  e_pbase    [N];
  logic [VA_W-1:0]  e_omask    [N];
  logic [PTE_W-1:0] e_pte      [N];
  logic [PA_W-1:0]  e_pte_addr [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    vtlb_slot #(
      .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .ASID_W(ASID_W), .AGE_W(AGE_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_vec[g]),
      .wr_asid    (ins_asid),
      .wr_glob    (ins_global),
      .wr_vtag    (wr_vtag),
      .wr_omask   (wr_omask),
      .wr_pbase   (wr_pbase),
      .wr_pte     (ins_pte),
      .wr_pte_addr(ins_pte_addr),
      .wr_age     (age_ctr),
      .fl_req     (fl_valid),
      .fl_kind    (fl_kind),
      .fl_asid    (fl_asid),
      .fl_addr    (fl_addr),
      .lk_asid    (lk_asid),
      .lk_vaddr   (lk_vaddr),
      .o_valid    (valid_vec[g]),
      .o_age      (e_age[g]),
      .o_hit      (hit_vec[g]),
      .o_pbase    (e_pbase[g]),
      .o_omask    (e_omask[g]),
      .o_pte      (e_pte[g]),
      .o_pte_addr (e_pte_addr[g])
    );
  end

  vtlb_victim #(.N(N), .AGE_W(AGE_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .ages      (e_age),
    .victim_idx(victim_idx)
  );

  vtlb_hitsel #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_hitsel (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_vec     (hit_vec),
    .lk_vaddr    (lk_vaddr),
    .pbase       (e_pbase),
    .omask       (e_omask),
    .pte         (e_pte),
    .pte_addr    (e_pte_addr),
    .any_hit     (lk_hit),
    .paddr       (lk_paddr),
    .pte_out     (lk_pte),
    .pte_addr_out(lk_pte_addr)
  );

  // R5
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_use_asid && !fl_use_addr) |=> (valid_vec == '0));

  // R9
  flush_beats_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && ins_valid) |=> ((valid_vec & ~$past(valid_vec)) == '0));

  // R11
  insert_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go |=> valid_vec[$past(victim_idx)]);

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0 && lk_pte == '0 && lk_pte_addr == '0));

endmodule

// File: tb/vtlb_assoc_test.sv
`timescale 1ns/1ps
module vtlb_assoc_test;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [8:0]  ins_asid = '0;
  logic        ins_global = 1'b0;
  logic [38:0] ins_vaddr = '0;
  logic [55:0] ins_paddr = '0;
  logic [63:0] ins_pte = '0;
  logic [55:0] ins_pte_addr = '0;
  logic [1:0]  ins_level = '0;
  logic [8:0]  lk_asid = '0;
  logic [38:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [55:0] lk_paddr;
  logic [63:0] lk_pte;
  logic [55:0] lk_pte_addr;
  logic        fl_valid = 1'b0;
  logic        fl_use_asid = 1'b0;
  logic [8:0]  fl_asid = '0;
  logic        fl_use_addr = 1'b0;
  logic [38:0] fl_addr = '0;

  always #10 clk = ~clk;

  vtlb_assoc uut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_asid(ins_asid), .ins_global(ins_global),
    .ins_vaddr(ins_vaddr), .ins_paddr(ins_paddr), .ins_pte(ins_pte),
    .ins_pte_addr(ins_pte_addr), .ins_level(ins_level),
    .lk_asid(lk_asid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .lk_pte(lk_pte), .lk_pte_addr(lk_pte_addr),
    .fl_valid(fl_valid), .fl_use_asid(fl_use_asid), .fl_asid(fl_asid),
    .fl_use_addr(fl_use_addr), .fl_addr(fl_addr)
  );

  // Reference model
  bit          mv    [N];
  logic [8:0]  masid [N];
  bit          mg    [N];
  logic [38:0] mtag  [N];
  logic [38:0] mmask [N];
  logic [55:0] mbase [N];
  logic [63:0] mpte  [N];
  logic [55:0] mpa   [N];
  int unsigned mseq  [N];
  int unsigned seqc = 1;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [38:0] pool [16];

  function automatic logic [38:0] bmask(input logic [1:0] lvl);
    int sh;
    logic [63:0] t;
    sh = 12 + 9 * ((lvl > 2) ? 2 : int'(lvl));
    t  = ~(64'hFFFF_FFFF_FFFF_FFFF << sh);
    return t[38:0];
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check_lookup(input string tag);
    logic        eh;
    logic [55:0] epa;
    logic [63:0] epte;
    logic [55:0] epta;
    eh = 0; epa = '0; epte = '0; epta = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mv[i] && (mg[i] || masid[i] == lk_asid) && mtag[i] == (lk_vaddr & ~mmask[i])) begin
        eh   = 1;
        epa  = mbase[i] | {17'b0, lk_vaddr & mmask[i]};
        epte = mpte[i];
        epta = mpa[i];
      end
    end
    n_cmp++;
    if ({lk_hit, lk_paddr, lk_pte, lk_pte_addr} !== {eh, epa, epte, epta}) begin
      n_bad++;
      $display("FAIL %s: hit=%0b pa=%h pte=%h ptea=%h, expected hit=%0b pa=%h pte=%h ptea=%h",
               tag, lk_hit, lk_paddr, lk_pte, lk_pte_addr, eh, epa, epte, epta);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
    end else if (fl_valid) begin
      for (int i = 0; i < N; i++) begin
        bit am, tm, k;
        am = (masid[i] == fl_asid) && !mg[i];
        tm = (mtag[i] == (fl_addr & ~mmask[i]));
        if (!fl_use_asid && !fl_use_addr) k = 1;
        else if (!fl_use_asid)            k = tm;
        else if (!fl_use_addr)            k = am;
        else                              k = am && tm;
        if (k) mv[i] = 0;
      end
    end else if (ins_valid) begin
      int v;
      logic [38:0] m;
      v = -1;
      for (int i = 0; i < N; i++) if (!mv[i] && v < 0) v = i;
      if (v < 0) begin
        v = 0;
        for (int i = 1; i < N; i++) if (mseq[i] < mseq[v]) v = i;
      end
      m        = bmask(ins_level);
      mv[v]    = 1;
      masid[v] = ins_asid;
      mg[v]    = ins_global;
      mmask[v] = m;
      mtag[v]  = ins_vaddr & ~m;
      mbase[v] = ins_paddr & ~{17'b0, m};
      mpte[v]  = ins_pte;
      mpa[v]   = ins_pte_addr;
      mseq[v]  = seqc;
      seqc++;
    end
  endtask

  // One cycle: check the lookup mid-cycle, advance the model at the edge
  task automatic cyc(input string tag);
    #1 check_lookup(tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    ins_valid = 1'b0;
    fl_valid  = 1'b0;
  endtask

  task automatic set_ins(input logic [8:0] a, input bit g, input logic [38:0] va,
                         input logic [55:0] pa, input logic [63:0] pte,
                         input logic [55:0] pta, input logic [1:0] lvl);
    ins_valid = 1'b1; ins_asid = a; ins_global = g; ins_vaddr = va;
    ins_paddr = pa; ins_pte = pte; ins_pte_addr = pta; ins_level = lvl;
  endtask

  task automatic set_fl(input bit ua, input logic [8:0] a, input bit ud, input logic [38:0] ad);
    fl_valid = 1'b1; fl_use_asid = ua; fl_asid = a; fl_use_addr = ud; fl_addr = ad;
  endtask

  task automatic set_lk(input logic [8:0] a, input logic [38:0] va);
    lk_asid = a; lk_vaddr = va;
  endtask

  // Directed entries used for lookup sweeps
  localparam logic [38:0] VA_A = 39'h00_4000_3000;
  localparam logic [38:0] VA_B = 39'h40_1234_5678;
  localparam logic [38:0] VA_C = 39'h11_8000_0000;
  localparam logic [38:0] VA_D = 39'h22_0000_7000;

  task automatic sweep(input string tag);
    set_lk(1, VA_A ^ 39'h123); cyc(tag);
    set_lk(2, VA_B ^ 39'h1FFF_FFFF); cyc(tag);
    set_lk(7, VA_C ^ 39'h555); cyc(tag);
    set_lk(3, VA_D); cyc(tag);
    set_lk(1, VA_D); cyc(tag);
  endtask

  task automatic load_set();
    set_ins(1, 0, VA_A, 56'h8_0000_5000, 64'hA1, 56'h100, 0); cyc("R11");
    set_ins(2, 0, VA_B, 56'hA_BCDE_F123, 64'hB2, 56'h108, 2); cyc("R2");
    set_ins(5, 1, VA_C, 56'h3_3333_3000, 64'hC3, 56'h110, 0); cyc("R3");
    set_ins(3, 0, VA_D, 56'h4_4444_4000, 64'hD4, 56'h118, 0); cyc("R3");
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin mv[i] = 0; mseq[i] = 0; end
    for (int i = 0; i < 16; i++) begin
      logic [63:0] r;
      r = rnd64();
      pool[i] = r[38:0];
    end

    // R1: reset state
    @(negedge clk);
    set_lk(1, 39'h12_3456_7000);
    cyc("R1");
    cyc("R1");
    rst_n = 1'b1;
    cyc("R1");

    // R11 then R2: insert visible only from the next cycle
    set_lk(1, VA_A ^ 39'habc);
    set_ins(1, 0, VA_A, 56'h8_0000_5000, 64'hA1, 56'h100, 0);
    cyc("R11");
    cyc("R2");

    // R2: level-2 superpage, offset bits flipped
    set_ins(2, 0, VA_B, 56'hA_BCDE_F123, 64'hB2, 56'h108, 2); cyc("R2");
    set_lk(2, VA_B ^ 39'h3FFF_FFFF); cyc("R2");
    set_lk(2, VA_B ^ 39'h4000_0000); cyc("R2");
    // R2: level code 3 clamps to level 2
    set_ins(6, 0, 39'h7_C000_0000, 56'h5_4000_0000, 64'hE5, 56'h120, 3); cyc("R2");
    set_lk(6, 39'h7_C000_0000 ^ 39'h2ABC_DEF0); cyc("R2");
    // R2: level 1
    set_ins(6, 0, 39'h3_0020_0000, 56'h9_0060_0000, 64'hE6, 56'h128, 1); cyc("R2");
    set_lk(6, 39'h3_0021_2345); cyc("R2");
    set_lk(6, 39'h3_0041_2345); cyc("R2");

    // R3: global matches any identifier, non-global does not
    set_ins(5, 1, VA_C, 56'h3_3333_3000, 64'hC3, 56'h110, 0); cyc("R3");
    set_lk(7, VA_C ^ 39'h777); cyc("R3");
    set_lk(3, VA_A); cyc("R3");

    // R4: overlapping superpage and base page, lowest index wins
    set_fl(0, 0, 0, 0); cyc("R5");
    set_ins(1, 0, 39'h5_0000_0000, 56'hF_0000_0000, 64'h51, 56'h200, 2); cyc("R4");
    set_ins(1, 0, 39'h5_0000_3000, 56'hE_0000_8000, 64'h52, 56'h208, 0); cyc("R4");
    set_lk(1, 39'h5_0000_3456); cyc("R4");
    set_lk(1, 39'h5_0000_4456); cyc("R4");
    set_fl(0, 0, 0, 0); cyc("R5");
    set_ins(1, 0, 39'h5_0000_3000, 56'hE_0000_8000, 64'h52, 56'h208, 0); cyc("R4");
    set_ins(1, 0, 39'h5_0000_0000, 56'hF_0000_0000, 64'h51, 56'h200, 2); cyc("R4");
    set_lk(1, 39'h5_0000_3456); cyc("R4");

    // R5: invalidate everything
    load_set();
    set_fl(0, 0, 0, 0); cyc("R5");
    sweep("R5");

    // R6: address-only, global included
    load_set();
    set_fl(0, 0, 1, VA_C ^ 39'h321); cyc("R6");
    sweep("R6");
    set_fl(0, 0, 1, VA_B ^ 39'h0ABC_DEF0); cyc("R6");
    sweep("R6");

    // R7: identifier-only, global kept
    set_fl(0, 0, 0, 0); cyc("R5");
    load_set();
    set_fl(1, 5, 0, 0); cyc("R7");
    sweep("R7");
    set_fl(1, 3, 0, 0); cyc("R7");
    sweep("R7");

    // R8: both enables
    set_fl(0, 0, 0, 0); cyc("R5");
    load_set();
    set_fl(1, 2, 1, VA_A); cyc("R8");
    sweep("R8");
    set_fl(1, 1, 1, VA_A); cyc("R8");
    sweep("R8");
    set_fl(1, 5, 1, VA_C); cyc("R8");
    sweep("R8");

    // R9: colliding insert and invalidate
    set_fl(0, 0, 0, 0); cyc("R5");
    set_lk(4, 39'h6_6666_6000);
    set_ins(4, 0, 39'h6_6666_6000, 56'h1_2345_6000, 64'h99, 56'h300, 0);
    set_fl(1, 4, 0, 0);
    cyc("R9");
    cyc("R9");

    // R10: fill past capacity, oldest goes
    for (int i = 0; i < N + 1; i++) begin
      set_ins(1, 0, 39'h10_0000_0000 + 39'(i) * 39'h1000, 56'(i) << 20, 64'(i + 16), 56'(i), 0);
      cyc("R10");
    end
    for (int i = 0; i < N + 1; i++) begin
      set_lk(1, 39'h10_0000_0000 + 39'(i) * 39'h1000);
      cyc("R10");
    end
    // Hole refill: invalidate one entry, the next insert lands there
    set_fl(0, 0, 1, 39'h10_0000_3000); cyc("R10");
    set_ins(1, 0, 39'h20_0000_0000, 56'h7_0000_0000, 64'h77, 56'h777, 0); cyc("R10");
    set_ins(1, 0, 39'h30_0000_0000, 56'h6_0000_0000, 64'h66, 56'h666, 0); cyc("R10");
    for (int i = 0; i < N + 1; i++) begin
      set_lk(1, 39'h10_0000_0000 + 39'(i) * 39'h1000);
      cyc("R10");
    end
    set_lk(1, 39'h20_0000_0000); cyc("R10");
    set_lk(1, 39'h30_0000_0000); cyc("R10");

    // Random mix, checked against the model (R3, R4, R6, R7, R8)
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [63:0] r;
      op = int'($urandom_range(0, 9));
      r  = rnd64();
      if (op <= 4 || op == 6) begin
        set_ins(9'($urandom_range(0, 3)), ($urandom_range(0, 5) == 0),
                pool[$urandom_range(0, 15)] ^ 39'(r[29:0]),
                56'(rnd64()), rnd64(), 56'(rnd64()), 2'($urandom_range(0, 3)));
      end
      if (op == 5 || op == 6) begin
        set_fl($urandom_range(0, 1) == 1, 9'($urandom_range(0, 3)),
               $urandom_range(0, 1) == 1, pool[$urandom_range(0, 15)] ^ 39'(r[40:30]));
      end
      set_lk(9'($urandom_range(0, 3)), pool[$urandom_range(0, 15)] ^ 39'(r[63:40]));
      cyc("R4");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule